// File: doc/BRIEF.md
# Prescaled Up-Counting Watchdog Timer

This block is a supervisory timer for a system processor. A free-running prescaler divides the system clock down to a 10 ms tick. On each tick a 15-bit count moves up by one, and the block compares that count with a 15-bit expiry limit that software programs. Software keeps the system alive by writing the main control word at regular intervals. Every such write sets the count back to zero.

When the count reaches a non-zero limit, the count stops there and a sticky expiry flag is raised. Two separate enables choose what expiry does. The first produces a one-cycle system reset request. The second holds a lockdown output that tells the packet fabric to drop traffic bound for the processor and to stop flow control on every port. A limit of zero turns expiry detection off, so a watchdog that has not been programmed never fires. The system clock frequency and the tick rate are parameters.

Top module: `tick_watchdog`

## Requirements
- R1: After reset both register words read as zero, and `expired`, `reset_req` and `lockdown` are low.
- R2: The count goes up by exactly one every CLK_HZ/TICK_HZ clock cycles. The prescaler runs freely from reset. After N clock edges with reset released, the count has moved once for every edge whose index is a multiple of that ratio.
- R3: The main word (`reg_sel` = 0) holds the reset enable in bit 31, the limit in bits 30:16, a reserved bit 15 that always reads 0, and the live count in bits 14:0. Writing this word loads the limit and the reset enable, and on the same edge sets the count to zero.
- R4: When the limit is non-zero and the count equals it, the count stays at the limit. `expired` goes high on the clock edge after the one on which the count reached the limit. While the limit is non-zero the count never goes past it.
- R5: `expired` stays high until the next write to the main word. That write clears it on its own edge.
- R6: `reset_req` is high for exactly one cycle, the first cycle of `expired`, and only when bit 31 of the main word is 1.
- R7: The lockdown word (`reg_sel` = 1) keeps only its bit 31, and its other bits read 0. `lockdown` is high exactly when `expired` is high and that bit is 1. A write to the lockdown word leaves the count untouched.
- R8: With a limit of zero the watchdog never expires, and the count wraps from 32767 to 0.
- R9: When a write to the main word and a tick fall on the same edge, the write wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted in step with `clk` |
| reg_wr | input | 1 | Write strobe for the selected register word |
| reg_sel | input | 1 | Word select: 0 = main control/count, 1 = lockdown control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| expired | output | 1 | Sticky expiry flag |
| reset_req | output | 1 | One-cycle system reset request |
| lockdown | output | 1 | Fabric lockdown request while expired and enabled |

## Verification
The hardest condition to reach from the ports is the wrap of the count at a zero limit. It needs 32768 ticks with no write to the main word in between. The bench runs with a prescale ratio of three, which brings the wrap within about 98k cycles, and it watches `expired` on every one of those cycles. The second hard case is a write to the main word landing on the same edge as a tick. The bench counts edges from reset release, so it knows the prescaler phase exactly. It then sweeps the write over all three phases, including the one that coincides with a tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register word select
  typedef enum logic {
    WDT_SEL_MAIN = 1'b0,
    WDT_SEL_LOCK = 1'b1
  } wdt_sel_e;

  // Default count width; the word layout below derives from it
  localparam int WDT_CNT_W_DEF = 15;

  function automatic int wdt_word_w(input int cw);
    return 2 * cw + 2;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

      logic [DIV_W-1:0] phase_q;
      logic [DIV_W-1:0] phase_d;
      logic             wrap;

      assign wrap = (phase_q == LAST);

      always_comb begin
        if (wrap) begin
          phase_d = '0;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_d;
        end
      end

      assign tick = wrap;
    end
  endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          armed;

  assign armed = (limit != '0);
  assign hit   = armed && (cnt_q == limit);

  // clock enable: a clear or a tick
  assign cnt_en = clear | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (tick && !hit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit,
  input  logic rst_en,
  input  logic lock_en,
  output logic expired,
  output logic reset_req,
  output logic lockdown
);

  logic exp_q;
  logic exp_d;
  logic req_q;
  logic req_d;

  always_comb begin
    if (clear) begin
      exp_d = 1'b0;
      req_d = 1'b0;
    end else begin
      exp_d = exp_q | hit;
      req_d = hit & ~exp_q & rst_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      exp_q <= exp_d;
      req_q <= req_d;
    end
  end

  assign expired   = exp_q;
  assign reset_req = req_q;
  assign lockdown  = exp_q & lock_en;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CW = 15,
  localparam int WW = 2 * CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel,
  input  logic [WW-1:0] wdata,
  input  logic [CW-1:0] count,
  output logic [WW-1:0] rdata,
  output logic          clear,
  output logic [CW-1:0] limit,
  output logic          rst_en,
  output logic          lock_en
);

  localparam int RSV_BIT = CW;
  localparam int LIM_LO  = CW + 1;
  localparam int LIM_HI  = 2 * CW;
  localparam int EN_BIT  = WW - 1;

  logic          wr_main;
  logic          wr_lock;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_d;
  logic          ren_q;
  logic          ren_d;
  logic          len_q;
  logic          len_d;
  logic          rsv_unused;

  assign wr_main    = wr_en && (wdt_sel_e'(sel) == WDT_SEL_MAIN);
  assign wr_lock    = wr_en && (wdt_sel_e'(sel) == WDT_SEL_LOCK);
  assign rsv_unused = wdata[RSV_BIT];

  always_comb begin
    lim_d = lim_q;
    ren_d = ren_q;
    len_d = len_q;
    if (wr_main) begin
      lim_d = wdata[LIM_HI:LIM_LO];
      ren_d = wdata[EN_BIT];
    end
    if (wr_lock) begin
      len_d = wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      ren_q <= 1'b0;
      len_q <= 1'b0;
    end else begin
      if (wr_main) begin
        lim_q <= lim_d;
        ren_q <= ren_d;
      end
      if (wr_lock) begin
        len_q <= len_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (wdt_sel_e'(sel))
      WDT_SEL_MAIN: begin
        rdata[EN_BIT]        = ren_q;
        rdata[LIM_HI:LIM_LO] = lim_q;
        rdata[RSV_BIT]       = 1'b0;
        rdata[CW-1:0]        = count;
      end
      default: begin
        rdata[EN_BIT] = len_q;
      end
    endcase
  end

  assign clear   = wr_main;
  assign limit   = lim_q;
  assign rst_en  = ren_q;
  assign lock_en = len_q;

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int CLK_HZ  = 100000000,
  parameter int TICK_HZ = 100,
  parameter int CNT_W   = 15,
  localparam int WORD_W = 2 * CNT_W + 2,
  localparam int DIV    = CLK_HZ / TICK_HZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              expired,
  output logic              reset_req,
  output logic              lockdown
);

  logic             tick_w;
  logic             clear_w;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] limit_w;
  logic             hit_w;
  logic             rst_en_w;
  logic             lock_en_w;

  wdt_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  wdt_regs #(.CW(CNT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .count  (count_w),
    .rdata  (reg_rdata),
    .clear  (clear_w),
    .limit  (limit_w),
    .rst_en (rst_en_w),
    .lock_en(lock_en_w)
  );

  wdt_counter #(.CW(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear_w),
    .tick (tick_w),
    .limit(limit_w),
    .count(count_w),
    .hit  (hit_w)
  );

  wdt_expiry u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_w),
    .hit      (hit_w),
    .rst_en   (rst_en_w),
    .lock_en  (lock_en_w),
    .expired  (expired),
    .reset_req(reset_req),
    .lockdown (lockdown)
  );

endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          clear,
  input logic [CW-1:0] count,
  input logic [CW-1:0] limit,
  input logic          expired,
  input logic          reset_req,
  input logic          lockdown
);

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(count)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0) && !expired); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (count <= limit)); // R4

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((limit != '0) && (count == limit) && !clear) |=> $stable(count)); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired); // R5

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R6

  AST_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (expired && $rose(expired))); // R6

  AST_LOCK_NEEDS_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |-> expired); // R7

  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !expired); // R8

endmodule

bind tick_watchdog tick_watchdog_chk #(.CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_w),
  .clear    (clear_w),
  .count    (count_w),
  .limit    (limit_w),
  .expired  (expired),
  .reset_req(reset_req),
  .lockdown (lockdown)
);

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;

  localparam int CLK_HZ  = 300;
  localparam int TICK_HZ = 100;
  localparam int RATIO   = CLK_HZ / TICK_HZ;
  localparam int WRAP    = 32768;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        expired;
  logic        reset_req;
  logic        lockdown;

  int tests;
  int fails;
  int edge_n;
  int w_edge;

  tick_watchdog #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .expired  (expired),
    .reset_req(reset_req),
    .lockdown (lockdown)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial edge_n = 0;
  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (edge %0d)", req, got, exp, edge_n);
    end
  endtask

  // ticks seen by the count since the last main-word write, after edge x
  function automatic int ticks_at(input int x);
    if (x <= w_edge) return 0;
    return x / RATIO - w_edge / RATIO;
  endfunction

  task automatic write_word(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_sel   = s;
    reg_wdata = d;
    @(negedge clk);
    reg_wr  = 1'b0;
    reg_sel = 1'b0;
    if (s == 1'b0) w_edge = edge_n;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end

  initial begin
    tests = 0; fails = 0; w_edge = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 main word", reg_rdata, 32'h0);
    check("R1 expired", {31'b0, expired}, 32'h0);
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);
    check("R1 lockdown", {31'b0, lockdown}, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1 lock word", reg_rdata, 32'h0);
    reg_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R2/R9: count cadence with the write at each prescaler phase
    for (int ph = 0; ph < RATIO; ph++) begin
      idle(ph + 1);
      write_word(1'b0, 32'h0);
      check(((w_edge % RATIO) == 0) ? "R9 write beats tick" : "R3 write clears",
            {17'b0, reg_rdata[14:0]}, 32'h0);
      for (int k = 0; k < 4 * RATIO; k++) begin
        @(negedge clk); #1;
        check("R2 cadence", {17'b0, reg_rdata[14:0]}, ticks_at(edge_n));
      end
      // R7: lock word write leaves count alone, other bits read 0
      write_word(1'b1, 32'h7fff_ffff);
      check("R7 count untouched", {17'b0, reg_rdata[14:0]}, ticks_at(edge_n));
      reg_sel = 1'b1; #1;
      check("R7 lock word bits", reg_rdata, 32'h0);
      reg_sel = 1'b0; #1;
    end

    // R3: layout, reserved bit reads 0
    write_word(1'b0, {1'b1, 15'h1234, 1'b1, 15'h7abc});
    check("R3 layout", reg_rdata, {1'b1, 15'h1234, 1'b0, 15'h0});

    // R4/R5/R6/R7: expiry sweep over limit, reset enable, lockdown enable
    for (int t = 1; t <= 5; t++) begin
      for (int en = 0; en < 2; en++) begin
        for (int lk = 0; lk < 2; lk++) begin
          int reach;
          logic e_exp;
          logic e_req;
          int e_cnt;
          write_word(1'b1, {lk[0], 31'h0});
          idle(t + en + lk);
          write_word(1'b0, {en[0], t[14:0], 1'b0, 15'h0});
          reach = (w_edge / RATIO + 1) * RATIO + RATIO * (t - 1);
          while (edge_n <= reach + 12) begin
            e_cnt = (ticks_at(edge_n) < t) ? ticks_at(edge_n) : t;
            e_exp = (ticks_at(edge_n - 1) >= t);
            e_req = en[0] && e_exp && (ticks_at(edge_n - 2) < t);
            check("R4 count saturates", {17'b0, reg_rdata[14:0]}, e_cnt);
            check("R5 expired", {31'b0, expired}, {31'b0, e_exp});
            check("R6 reset pulse", {31'b0, reset_req}, {31'b0, e_req});
            check("R7 lockdown", {31'b0, lockdown}, {31'b0, e_exp & lk[0]});
            @(negedge clk); #1;
          end
          write_word(1'b0, 32'h0);
          check("R5 cleared by write", {31'b0, expired}, 32'h0);
          check("R7 lockdown released", {31'b0, lockdown}, 32'h0);
        end
      end
    end

    // R8: zero limit never expires and the count wraps
    write_word(1'b1, 32'h8000_0000);
    write_word(1'b0, 32'h0);
    begin
      logic seen;
      seen = 1'b0;
      while (ticks_at(edge_n) < WRAP + 2) begin
        if (expired || reset_req || lockdown) seen = 1'b1;
        @(negedge clk); #1;
      end
      check("R8 never expired", {31'b0, seen}, 32'h0);
      check("R8 count wrapped", {17'b0, reg_rdata[14:0]}, ticks_at(edge_n) % WRAP);
    end

    finish_run();
  end

endmodule